// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block reads ahead from a NAND-style data port into a 64-byte circular buffer, so that a CPU or DMA master can drain the data one byte at a time without waiting on the device. Software first writes a configuration word and a transfer length in bytes. A start command then copies the length into a working remaining-count and empties the buffer. The engine fills the buffer from the device, and after that it tops the buffer up whenever the free space reaches a programmable threshold. It does not wait for the buffer to run empty. The length is always a byte count, even when the device delivers 16 bits per access.

The device side is a request stream. The engine raises `dev_rd_req` and holds it until the device answers with `dev_rd_ack` in the same cycle as valid `dev_rd_data`. A high ready transfers one access, and a low ready stalls the engine with nothing lost. The engine reserves buffer space before it issues a request, so it never refuses returned data. The bus side is a plain read strobe: `bus_rdata` always shows the byte that the next strobe will consume. A DMA request line tells a DMA master that a refill has landed.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset, busy, dma_req, tc_pulse, dev_rd_req, remain_cnt and fill_level are all 0. A start command (ctl_we with ctl_start=1) that arrives while the engine is idle and configuration bit 7 (enable) is 1 sets busy, loads remain_cnt from the stored length and empties the buffer, all on the next clock edge. When enable is 0 the start command is ignored.
- R2: When idle, a configuration write stores the written word masked to its defined fields: bit 0 write mode, bit 2 DMA enable, bit 7 enable, bits 14:8 threshold, bits 26:24 chip-select. The mask is 0x07007F85. While busy, configuration and length writes are ignored.
- R3: The first refill after a start, and every later refill, fetches min(64 - fill_level, remain_cnt) bytes. remain_cnt drops by that amount when the refill is launched. A later refill is launched only when no refill is in flight and the free space (64 - fill_level) is at least the threshold.
- R4: The device request stays high until it is acknowledged. Width 8 (dev_wide=0) gives one byte per access. Width 16 gives two bytes per access, the low byte (bits 7:0) first. An odd final byte of a refill keeps only the low byte. dev_cs follows configuration bits 26:24.
- R5: In read mode, a bus_rd returns the oldest buffered byte on bus_rdata and lowers fill_level by one. A bus_rd on an empty buffer returns the previously read byte again and leaves fill_level at 0.
- R6: While configuration bit 0 is 1 (write mode), bus_rdata is 0 and a bus_rd consumes nothing.
- R7: dma_req falls when a refill is launched. It rises when a refill completes and leaves the buffer non-empty, but only if bit 2 is 1. It never rises while bit 2 is 0.
- R8: When a launch drives remain_cnt to 0 while the engine is busy, busy falls and tc_pulse is high for exactly one cycle.
- R9: A stop command (ctl_we with ctl_start=0) issued while busy clears busy and remain_cnt and abandons the unfinished refill. No further device requests follow. Bytes already buffered can still be drained in order.
- R10: fill_level never exceeds 64. A fill and a drain in the same cycle are both counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| len_we | input | 1 | Length write strobe |
| len_wdata | input | 14 | Transfer length in bytes |
| ctl_we | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start (1) or stop (0) value |
| cfg_q | output | 32 | Stored configuration |
| len_q | output | 14 | Stored length |
| busy | output | 1 | Engine running |
| remain_cnt | output | 14 | Bytes not yet requested |
| fill_level | output | 7 | Bytes held in buffer |
| tc_pulse | output | 1 | Terminal-count pulse |
| dma_req | output | 1 | DMA request |
| bus_rd | input | 1 | Bus byte read strobe |
| bus_rdata | output | 8 | Byte at buffer head |
| dev_wide | input | 1 | Device is 16 bits wide |
| dev_cs | output | 3 | Selected chip-select |
| dev_rd_req | output | 1 | Device read request (valid) |
| dev_rd_ack | input | 1 | Device ready, data valid |
| dev_rd_data | input | 16 | Device read data |

## Verification
The bench builds the block with its default 64-byte buffer and 14-bit length. This lets a first fill saturate the buffer, and lets lengths of 150 bytes need several threshold-driven refills plus a short final one. The bench sweeps thresholds of 8, 16 and 32, both device widths, lengths below, at and above the buffer size, and an always-ready and a stalling device. It also covers drains that overlap refills, an odd tail on the 16-bit port, and a stop in the middle of a refill.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;
  localparam int CFG_W   = 32;
  localparam int BIT_WR  = 0;
  localparam int BIT_DMA = 2;
  localparam int BIT_EN  = 7;
  localparam int THR_LSB = 8;
  localparam int THR_W   = 7;
  localparam int CS_LSB  = 24;
  localparam int CS_W    = 3;
  localparam logic [CFG_W-1:0] CFG_MASK = 32'h0700_7F85;

  typedef struct packed {
    logic             wr_mode;
    logic             dma_en;
    logic             eng_en;
    logic [THR_W-1:0] thr;
    logic [CS_W-1:0]  cs;
  } cfg_t;
endpackage

// File: rtl/nand_pf_ctrl.sv
module nand_pf_ctrl
  import nand_pf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  parameter int OCC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             len_we,
  input  logic [CNT_W-1:0] len_wdata,
  input  logic             ctl_we,
  input  logic             ctl_start,
  input  logic             wr_mode,
  input  logic             dma_en,
  input  logic             eng_en,
  input  logic [THR_W-1:0] thr,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] occ_nxt,
  input  logic             fetch_idle,
  input  logic             fetch_done,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CNT_W-1:0] len_q,
  output logic             busy,
  output logic [CNT_W-1:0] remain,
  output logic             launch,
  output logic [OCC_W-1:0] launch_n,
  output logic             dma_req,
  output logic             tc,
  output logic             abort,
  output logic             flush
);
  logic             busy_q, first_q, dma_q, tc_q;
  logic [CNT_W-1:0] remain_q, remain_after;
  logic [OCC_W-1:0] free;
  logic             start_evt, stop_evt;

  always_comb begin
    start_evt    = ctl_we && ctl_start && !busy_q && eng_en;
    stop_evt     = ctl_we && !ctl_start && busy_q;
    free         = OCC_W'(DEPTH) - occ;
    launch_n     = (remain_q < CNT_W'(free)) ? OCC_W'(remain_q) : free;
    launch       = fetch_idle && !wr_mode && (remain_q != '0) && (free != '0) &&
                   (first_q || (int'(free) >= int'(thr))) && !start_evt && !stop_evt;
    remain_after = remain_q - CNT_W'(launch_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      len_q    <= '0;
      busy_q   <= 1'b0;
      first_q  <= 1'b0;
      dma_q    <= 1'b0;
      tc_q     <= 1'b0;
      remain_q <= '0;
    end else begin
      if (cfg_we && !busy_q) cfg_q <= cfg_wdata & CFG_MASK;
      if (len_we && !busy_q) len_q <= len_wdata;
      tc_q <= 1'b0;
      if (start_evt) begin
        busy_q   <= 1'b1;
        remain_q <= len_q;
        first_q  <= 1'b1;
        dma_q    <= 1'b0;
      end else if (stop_evt) begin
        busy_q   <= 1'b0;
        remain_q <= '0;
        first_q  <= 1'b0;
      end else if (launch) begin
        remain_q <= remain_after;
        first_q  <= 1'b0;
        dma_q    <= 1'b0;
        if (remain_after == '0 && busy_q) begin
          busy_q <= 1'b0;
          tc_q   <= 1'b1;
        end
      end
      if (fetch_done && occ_nxt != '0 && dma_en) dma_q <= 1'b1;
    end
  end

  assign busy    = busy_q;
  assign remain  = remain_q;
  assign dma_req = dma_q;
  assign tc      = tc_q;
  assign abort   = start_evt || stop_evt;
  assign flush   = start_evt;
endmodule

// File: rtl/nand_pf_fetch.sv
module nand_pf_fetch #(
  parameter int OCC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [OCC_W-1:0] launch_n,
  input  logic             abort,
  input  logic             wide,
  output logic             dev_req,
  input  logic             dev_ack,
  output logic             idle,
  output logic             push,
  output logic             push_two,
  output logic             done
);
  logic [OCC_W-1:0] left_q, step;
  logic             fire, take_two;

  always_comb begin
    dev_req  = (left_q != '0);
    fire     = dev_req && dev_ack;
    take_two = wide && (left_q >= OCC_W'(2));
    step     = take_two ? OCC_W'(2) : OCC_W'(1);
    idle     = !dev_req;
    push     = fire;
    push_two = fire && take_two;
    done     = fire && (left_q == step) && !abort;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      left_q <= '0;
    else if (abort)  left_q <= '0;
    else if (launch) left_q <= launch_n;
    else if (fire)   left_q <= left_q - step;
  end
endmodule

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo #(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int OCC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_two,
  input  logic [15:0]      push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [7:0]       rdata,
  output logic [OCC_W-1:0] occ,
  output logic [OCC_W-1:0] occ_nxt
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ_q, push_n;
  logic [7:0]       last_q;
  logic             pop_ok, wr_ok;

  always_comb begin
    pop_ok  = pop && (occ_q != '0);
    wr_ok   = push && !flush;
    push_n  = wr_ok ? (push_two ? OCC_W'(2) : OCC_W'(1)) : '0;
    occ_nxt = flush ? '0 : (occ_q + push_n - OCC_W'(pop_ok));
    rdata   = (occ_q != '0) ? mem[rd_ptr] : last_q;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_ptr] <= push_data[7:0];
      if (push_two) mem[wr_ptr + PTR_W'(1)] <= push_data[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
      last_q <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      occ_q  <= occ_nxt;
      if (flush) rd_ptr <= wr_ptr;
      else if (pop_ok) begin
        rd_ptr <= rd_ptr + PTR_W'(1);
        last_q <= mem[rd_ptr];
      end
    end
  end

  assign occ = occ_q;
endmodule

// File: rtl/nand_prefetch_engine.sv
module nand_prefetch_engine
  import nand_pf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             len_we,
  input  logic [CNT_W-1:0] len_wdata,
  input  logic             ctl_we,
  input  logic             ctl_start,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CNT_W-1:0] len_q,
  output logic             busy,
  output logic [CNT_W-1:0] remain_cnt,
  output logic [OCC_W-1:0] fill_level,
  output logic             tc_pulse,
  output logic             dma_req,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  input  logic             dev_wide,
  output logic [CS_W-1:0]  dev_cs,
  output logic             dev_rd_req,
  input  logic             dev_rd_ack,
  input  logic [15:0]      dev_rd_data
);
  cfg_t             cfg_f;
  logic             launch, fetch_idle, fetch_done, abort, flush;
  logic             push, push_two;
  logic [OCC_W-1:0] launch_n, occ_nxt;
  logic [7:0]       fifo_rdata;

  assign cfg_f = '{wr_mode: cfg_q[BIT_WR], dma_en: cfg_q[BIT_DMA], eng_en: cfg_q[BIT_EN],
                   thr: cfg_q[THR_LSB +: THR_W], cs: cfg_q[CS_LSB +: CS_W]};

  nand_pf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .ctl_we(ctl_we), .ctl_start(ctl_start),
    .wr_mode(cfg_f.wr_mode), .dma_en(cfg_f.dma_en), .eng_en(cfg_f.eng_en), .thr(cfg_f.thr),
    .occ(fill_level), .occ_nxt(occ_nxt), .fetch_idle(fetch_idle), .fetch_done(fetch_done),
    .cfg_q(cfg_q), .len_q(len_q), .busy(busy), .remain(remain_cnt), .launch(launch),
    .launch_n(launch_n), .dma_req(dma_req), .tc(tc_pulse), .abort(abort), .flush(flush)
  );

  nand_pf_fetch #(.OCC_W(OCC_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_n(launch_n), .abort(abort),
    .wide(dev_wide), .dev_req(dev_rd_req), .dev_ack(dev_rd_ack), .idle(fetch_idle),
    .push(push), .push_two(push_two), .done(fetch_done)
  );

  nand_pf_fifo #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OCC_W(OCC_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_two(push_two), .push_data(dev_rd_data),
    .pop(bus_rd && !cfg_f.wr_mode), .flush(flush), .rdata(fifo_rdata),
    .occ(fill_level), .occ_nxt(occ_nxt)
  );

  assign bus_rdata = cfg_f.wr_mode ? 8'h00 : fifo_rdata;
  assign dev_cs    = cfg_f.cs;
endmodule

// File: rtl/nand_pf_checker.sv
module nand_pf_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  parameter int OCC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic             ctl_start,
  input logic [31:0]      cfg_q,
  input logic [CNT_W-1:0] len_q,
  input logic             busy,
  input logic [CNT_W-1:0] remain_cnt,
  input logic [OCC_W-1:0] fill_level,
  input logic             tc_pulse,
  input logic             dma_req,
  input logic [7:0]       bus_rdata,
  input logic             dev_rd_req,
  input logic             dev_rd_ack
);
  a_r2_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_q) && $stable(len_q)));
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd_req && !dev_rd_ack && !ctl_we) |=> dev_rd_req);
  a_r6_write_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[0] |-> (bus_rdata == 8'h00));
  a_r7_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> cfg_q[2]);
  a_r8_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);
  a_r8_tc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (!busy && remain_cnt == '0));
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we && !ctl_start) |=> (!busy && remain_cnt == '0));
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_level) <= DEPTH);
endmodule

bind nand_prefetch_engine nand_pf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start), .cfg_q(cfg_q),
  .len_q(len_q), .busy(busy), .remain_cnt(remain_cnt), .fill_level(fill_level),
  .tc_pulse(tc_pulse), .dma_req(dma_req), .bus_rdata(bus_rdata),
  .dev_rd_req(dev_rd_req), .dev_rd_ack(dev_rd_ack)
);

// File: tb/tb_nand_prefetch_engine.sv
module tb_nand_prefetch_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, len_we = 0, ctl_we = 0, ctl_start = 0, bus_rd = 0, dev_wide = 0;
  logic [31:0] cfg_wdata = '0, cfg_q;
  logic [13:0] len_wdata = '0, len_q, remain_cnt;
  logic [6:0]  fill_level;
  logic        busy, tc_pulse, dma_req, dev_rd_req, dev_rd_ack;
  logic [7:0]  bus_rdata;
  logic [2:0]  dev_cs;
  logic [15:0] dev_rd_data;
  int n_tests = 0, n_fail = 0;
  int dev_addr = 0, acc = 0, tc_seen = 0, ovf = 0, cyc = 0, stall_mode = 0;

  always #10 clk = ~clk;

  nand_prefetch_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .len_we(len_we),
    .len_wdata(len_wdata), .ctl_we(ctl_we), .ctl_start(ctl_start), .cfg_q(cfg_q),
    .len_q(len_q), .busy(busy), .remain_cnt(remain_cnt), .fill_level(fill_level),
    .tc_pulse(tc_pulse), .dma_req(dma_req), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dev_wide(dev_wide), .dev_cs(dev_cs), .dev_rd_req(dev_rd_req), .dev_rd_ack(dev_rd_ack),
    .dev_rd_data(dev_rd_data)
  );

  function automatic logic [7:0] dv(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] mk_cfg(input bit wr, input bit dma, input bit en,
                                         input int thr, input int cs);
    return {5'b0, 3'(cs), 9'b0, 7'(thr), en, 4'b0, dma, 1'b0, wr};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // device model: ready pattern, data derived from byte address
  initial begin
    dev_rd_ack = 1'b0;
    dev_rd_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (tc_pulse) tc_seen++;
      if (fill_level > 7'd64) ovf++;
      dev_rd_data = {dv(dev_addr + 1), dv(dev_addr)};
      dev_rd_ack  = (stall_mode == 0) || (cyc % 3 != 0);
      if (dev_rd_req && dev_rd_ack) begin
        dev_addr += dev_wide ? 2 : 1;
        acc++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic put_cfg(input logic [31:0] w);
    cfg_wdata = w; cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask
  task automatic put_len(input int n);
    len_wdata = 14'(n); len_we = 1; @(negedge clk); len_we = 0;
  endtask
  task automatic put_ctl(input bit s);
    ctl_start = s; ctl_we = 1; @(negedge clk); ctl_we = 0;
  endtask
  task automatic rd(output logic [7:0] b);
    b = bus_rdata; bus_rd = 1; @(negedge clk); bus_rd = 0;
  endtask
  task automatic wait_dma();
    int n = 0;
    while (!dma_req && n < 4000) begin @(negedge clk); n++; end
    chk(dma_req, "R7 dma_req rises after refill", dma_req, 1);
  endtask
  task automatic prep(input bit wide, input int stall);
    dev_wide = wide; stall_mode = stall; dev_addr = 0; acc = 0; tc_seen = 0;
  endtask

  task automatic run_xfer(input bit wide, input int thr, input int len, input int stall);
    int first, drained, burst;
    logic [7:0] b;
    prep(wide, stall);
    put_cfg(mk_cfg(0, 1, 1, thr, 5));
    put_len(len);
    put_ctl(1);
    chk(busy && remain_cnt == 14'(len) && fill_level == 0, "R1 start loads count", remain_cnt, len);
    chk(dev_cs == 3'd5, "R4 chip-select", dev_cs, 5);
    first = (len < 64) ? len : 64;
    wait_dma();
    chk(fill_level == 7'(first), "R3 first fill size", fill_level, first);
    chk(remain_cnt == 14'(len - first), "R3 remaining after first fill", remain_cnt, len - first);
    drained = 0;
    while (drained < len) begin
      wait_dma();
      burst = (len - drained < thr) ? len - drained : thr;
      for (int i = 0; i < burst; i++) begin
        rd(b);
        chk(b == dv(drained), "R5 drained byte order", b, dv(drained));
        drained++;
      end
      repeat (2) @(negedge clk);
    end
    chk(tc_seen == 1 && !busy && remain_cnt == 0, "R8 single terminal count", tc_seen, 1);
    chk(acc == (wide ? len / 2 : len), "R4 device access count", acc, wide ? len / 2 : len);
    rd(b);
    chk(b == dv(len - 1) && fill_level == 0, "R5 empty read repeats", b, dv(len - 1));
  endtask

  initial begin
    logic [7:0] b;
    int lens[4] = '{6, 37, 64, 150};
    int thrs[3] = '{8, 16, 32};
    int f, drained, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !dma_req && !tc_pulse && !dev_rd_req && remain_cnt == 0 && fill_level == 0,
        "R1 reset state", {busy, dma_req, dev_rd_req}, 0);

    // sweep widths, thresholds, lengths and ready patterns
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 3; t++)
        for (int l = 0; l < 4; l++)
          for (int s = 0; s < 2; s++)
            if (!(w == 1 && lens[l] % 2 == 1)) run_xfer(w[0], thrs[t], lens[l], s);

    // R4: odd tail on 16-bit port keeps only the low byte
    prep(1, 0);
    put_cfg(mk_cfg(0, 1, 1, 8, 2));
    put_len(5);
    put_ctl(1);
    wait_dma();
    chk(fill_level == 5 && acc == 3, "R4 odd tail on wide port", acc, 3);
    for (int i = 0; i < 5; i++) begin
      rd(b);
      chk(b == dv(i), "R4 wide byte order low first", b, dv(i));
    end

    // R6: write mode reads zero and consumes nothing
    prep(0, 0);
    put_cfg(mk_cfg(0, 1, 1, 8, 0));
    put_len(20);
    put_ctl(1);
    wait_dma();
    put_cfg(mk_cfg(1, 1, 1, 8, 0));
    rd(b);
    chk(b == 0 && fill_level == 20, "R6 write-mode read", b, 0);
    put_cfg(mk_cfg(0, 1, 1, 8, 0));
    rd(b);
    chk(b == dv(0), "R6 no byte consumed", b, dv(0));

    // R2: mask and busy freeze
    put_cfg(32'hFFFF_FFFE);
    chk(cfg_q == 32'h0700_7F84, "R2 config mask", cfg_q, 32'h0700_7F84);
    prep(0, 1);
    put_cfg(mk_cfg(0, 1, 1, 16, 1));
    put_len(300);
    put_ctl(1);
    put_cfg(mk_cfg(0, 0, 1, 40, 6));
    put_len(77);
    chk(cfg_q == mk_cfg(0, 1, 1, 16, 1), "R2 config frozen", cfg_q, mk_cfg(0, 1, 1, 16, 1));
    chk(len_q == 300, "R2 length frozen", len_q, 300);

    // R9: stop mid-refill, drain leftovers
    wait_dma();
    for (int i = 0; i < 16; i++) rd(b);
    @(negedge clk);
    put_ctl(0);
    chk(!busy && remain_cnt == 0, "R9 stop clears", remain_cnt, 0);
    n = acc;
    f = fill_level;
    for (int i = 0; i < f; i++) begin
      rd(b);
      chk(b == dv(16 + i), "R9 leftover bytes drain", b, dv(16 + i));
    end
    repeat (20) @(negedge clk);
    chk(acc == n && !dev_rd_req && fill_level == 0, "R9 no device reads after stop", acc, n);

    // R1: start ignored with enable clear
    put_cfg(mk_cfg(0, 1, 0, 8, 0));
    put_len(10);
    put_ctl(1);
    repeat (5) @(negedge clk);
    chk(!busy && remain_cnt == 0 && !dev_rd_req, "R1 start needs enable", busy, 0);

    // R7: DMA disabled keeps request low
    prep(0, 0);
    put_cfg(mk_cfg(0, 0, 1, 8, 0));
    put_len(40);
    put_ctl(1);
    repeat (100) @(negedge clk);
    chk(fill_level == 40 && !dma_req, "R7 dma gated off", dma_req, 0);
    for (int i = 0; i < 40; i++) begin
      rd(b);
      chk(b == dv(i), "R7 data without dma", b, dv(i));
    end

    // R10: drain while refills run
    prep(0, 1);
    put_cfg(mk_cfg(0, 1, 1, 32, 0));
    put_len(150);
    put_ctl(1);
    drained = 0;
    n = 0;
    while (drained < 150 && n < 5000) begin
      if (fill_level != 0) begin
        rd(b);
        chk(b == dv(drained), "R10 overlapped drain", b, dv(drained));
        drained++;
      end else @(negedge clk);
      n++;
    end
    chk(drained == 150 && ovf == 0, "R10 all bytes, no overflow", drained, 150);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule